// File: doc/BRIEF.md
# Serial Burst RAM Access Controller

This block sits behind a byte-wide serial control port framed by an active-low chip select. The first byte after chip select falls is a command. A command either loads the channel-enable mask or starts a burst read or write into one of two word memories. The first memory holds tone data: 32 words of 16 bits, shared by every channel. The second holds coefficients: each channel owns 12 blocks of eight 14-bit words.

Every word crosses the port as two bytes, high byte first. A burst always walks its addresses downward. A tone-data burst starts at the address in the command and runs down to address 0. A coefficient burst covers all eight words of the named block, from the highest word to the lowest. Releasing chip select ends the transaction at once. Words that were already complete stay in memory. The word in progress is dropped, and so are all the words after it.

The host strobes `slot` once per byte. It samples `tx_byte` before that strobe, while it presents the next byte on `rx_byte`.

Top module: `burst_ram_port`

## Requirements
- R1: A tone-data write command has bit 7 = 0, bit 6 = 1 and bit 5 = 0. Bits 4:0 give the start address S. The block then takes (S+1)*2 data bytes. It stores them as words at addresses S, S-1, ... 0, with the high byte of each word first.
- R2: A tone-data read command has bit 7 = 1, bit 6 = 1 and bit 5 = 0. For each data slot, the block presents the stored words from address S down to 0 on `tx_byte`, with the high byte of each word first.
- R3: A coefficient command has bit 6 = 0 and bit 5 = 0. Bits 4:0 give the block index B, and bit 7 selects read (1) or write (0). The command transfers exactly eight words, at word addresses B*8+7 down to B*8.
- R4: A coefficient write keeps only the low 14 bits of each 16-bit word. On a coefficient read, the two top bits of the high byte are always zero.
- R5: A byte with bit 5 = 1 in command position sets the channel-enable mask to bits 3:0, and the mask persists across chip-select cycles. A coefficient write stores into every enabled channel. A coefficient read returns the lowest-numbered enabled channel, and returns zero when the mask is empty.
- R6: A coefficient command whose block index is 12 or more touches no memory. Every later byte, until chip select rises, is ignored: it is not taken as a command, and `tx_byte` stays zero.
- R7: When chip select rises partway through a burst, every word whose second byte was received stays written. A half-received word is never written.
- R8: When a burst's last byte completes, the next byte under the same chip select is decoded as a new command.
- R9: After reset, and at every time no read burst is in its data phase, `tx_byte` is zero. Reset clears the mask to zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cs_n | input | 1 | Active-low chip select; when high, it ends the transaction |
| slot | input | 1 | One-cycle strobe per byte transferred |
| rx_byte | input | 8 | Byte from the host, taken on `slot` |
| tx_byte | output | 8 | Byte to the host for the current data slot |

## Verification
The bench drives chip select high at random points inside bursts, including just after the first byte of a word. A design that commits half words, or loses completed ones, then reads back data that differs from the model. The bench also sends coefficient block indices of 12 and above, followed by a byte that looks like a mask command. A design that decodes such trailing bytes changes the mask, and later reads come from the wrong channel. Overlapping channel masks, an empty mask and back-to-back commands under one chip select expose wrong channel priority, reads that are not zero, and an end-of-burst hand-off that is off by one.

// File: rtl/brp_pkg.sv
package brp_pkg;
   typedef enum logic [1:0] {
      ST_CMD  = 2'd0,
      ST_DATA = 2'd1,
      ST_SKIP = 2'd2
   } burst_st_t;

   typedef struct packed {
      logic       is_chan;
      logic       is_read;
      logic       is_tone;
      logic [4:0] field;
   } cmd_t;
endpackage

// File: rtl/brp_cmd_decode.sv
module brp_cmd_decode
   import brp_pkg::*;
#(
   parameter int COEF_BLOCKS = 12
) (
   input  logic [7:0] cmd_byte,
   output cmd_t       cmd_o,
   output logic       block_ok_o
);
   generate
      if (COEF_BLOCKS < 1 || COEF_BLOCKS > 32) begin : g_bad_blocks
         $error("COEF_BLOCKS must fit the 5-bit field");
      end
   endgenerate

   always_comb begin
      cmd_o.is_read = cmd_byte[7];
      cmd_o.is_tone = cmd_byte[6];
      cmd_o.is_chan = cmd_byte[5];
      cmd_o.field   = cmd_byte[4:0];
      block_ok_o    = (32'(cmd_byte[4:0]) < COEF_BLOCKS);
   end
endmodule

// File: rtl/brp_burst_ctrl.sv
module brp_burst_ctrl
   import brp_pkg::*;
#(
   parameter int NUM_CH      = 4,
   parameter int ADDR_W      = 7,
   parameter int TONE_AW     = 5,
   parameter int BLK_SHIFT   = 3,
   parameter int COEF_BLOCKS = 12,
   parameter int WORD_W      = 16
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cs_n,
   input  logic              slot,
   input  logic [7:0]        rx_byte,
   output logic [ADDR_W-1:0] addr_o,
   output logic [WORD_W-1:0] wdata_o,
   output logic              tone_we_o,
   output logic              coef_we_o,
   output logic              rd_active_o,
   output logic              rd_tone_o,
   output logic              rd_lo_o,
   output logic [NUM_CH-1:0] mask_o
);
   localparam int BLK_W = $clog2(COEF_BLOCKS);

   generate
      if (WORD_W != 16) begin : g_bad_word
         $error("WORD_W must be two bytes");
      end
      if (NUM_CH < 1 || NUM_CH > 5) begin : g_bad_ch
         $error("NUM_CH must fit the mask field");
      end
      if (TONE_AW > 5 || TONE_AW > ADDR_W) begin : g_bad_tone
         $error("TONE_AW out of range");
      end
      if (BLK_W + BLK_SHIFT > ADDR_W) begin : g_bad_addr
         $error("ADDR_W too small for coefficient space");
      end
   endgenerate

   cmd_t              cmd;
   logic              block_ok;
   burst_st_t         st;
   logic              lo_q, read_q, tone_q;
   logic [7:0]        hi_q;
   logic [ADDR_W-1:0] addr_q;
   logic [NUM_CH-1:0] mask_q;
   logic              fire, last_word, word_done;
   logic [ADDR_W-1:0] tone_start, coef_start;

   brp_cmd_decode #(.COEF_BLOCKS(COEF_BLOCKS)) dec_i (
      .cmd_byte   (rx_byte),
      .cmd_o      (cmd),
      .block_ok_o (block_ok)
   );

   assign fire       = slot && !cs_n;
   assign tone_start = ADDR_W'(cmd.field[TONE_AW-1:0]);
   assign coef_start = ADDR_W'({cmd.field[BLK_W-1:0], {BLK_SHIFT{1'b1}}});
   assign last_word  = tone_q ? (addr_q == '0) : (addr_q[BLK_SHIFT-1:0] == '0);
   assign word_done  = fire && (st == ST_DATA) && lo_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st     <= ST_CMD;
         lo_q   <= 1'b0;
         read_q <= 1'b0;
         tone_q <= 1'b0;
         hi_q   <= '0;
         addr_q <= '0;
         mask_q <= '0;
      end else if (cs_n) begin
         st   <= ST_CMD;
         lo_q <= 1'b0;
      end else if (slot) begin
         unique case (st)
            ST_CMD: begin
               if (cmd.is_chan) begin
                  mask_q <= cmd.field[NUM_CH-1:0];
               end else begin
                  read_q <= cmd.is_read;
                  tone_q <= cmd.is_tone;
                  lo_q   <= 1'b0;
                  if (cmd.is_tone) begin
                     addr_q <= tone_start;
                     st     <= ST_DATA;
                  end else if (block_ok) begin
                     addr_q <= coef_start;
                     st     <= ST_DATA;
                  end else begin
                     st <= ST_SKIP;
                  end
               end
            end
            ST_DATA: begin
               if (!lo_q) begin
                  hi_q <= rx_byte;
                  lo_q <= 1'b1;
               end else begin
                  lo_q <= 1'b0;
                  if (last_word) st <= ST_CMD;
                  else addr_q <= addr_q - 1'b1;
               end
            end
            default: ;
         endcase
      end
   end

   assign addr_o      = addr_q;
   assign wdata_o     = {hi_q, rx_byte};
   assign tone_we_o   = word_done && !read_q && tone_q;
   assign coef_we_o   = word_done && !read_q && !tone_q;
   assign rd_active_o = (st == ST_DATA) && read_q;
   assign rd_tone_o   = tone_q;
   assign rd_lo_o     = lo_q;
   assign mask_o      = mask_q;

   assert_cs_release_R7: assert property (@(posedge clk) disable iff (!rst_n)
      cs_n |=> (st == ST_CMD && !lo_q));

   assert_addr_down_R1: assert property (@(posedge clk) disable iff (!rst_n)
      (word_done && !last_word) |=> (addr_q == $past(addr_q) - 1'b1));

   assert_burst_end_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (word_done && last_word) |=> (st == ST_CMD));

   assert_block_range_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (st == ST_DATA && !tone_q) |-> (32'(addr_q >> BLK_SHIFT) < COEF_BLOCKS));
endmodule

// File: rtl/brp_tone_ram.sv
module brp_tone_ram #(
   parameter int DEPTH = 32,
   parameter int W     = 16
) (
   input  logic                     clk,
   input  logic                     we,
   input  logic [$clog2(DEPTH)-1:0] addr,
   input  logic [W-1:0]             wdata,
   output logic [W-1:0]             rdata
);
   logic [W-1:0] mem [DEPTH];

   always_ff @(posedge clk) begin
      if (we) mem[addr] <= wdata;
   end

   assign rdata = mem[addr];
endmodule

// File: rtl/brp_coef_bank.sv
module brp_coef_bank #(
   parameter int NUM_CH = 4,
   parameter int DEPTH  = 96,
   parameter int W      = 14
) (
   input  logic                            clk,
   input  logic                            we,
   input  logic [NUM_CH-1:0]               mask,
   input  logic [$clog2(DEPTH)-1:0]        addr,
   input  logic [W-1:0]                    wdata,
   output logic [NUM_CH-1:0][W-1:0]        rdata_all
);
   generate
      for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
         logic [W-1:0] mem [DEPTH];
         always_ff @(posedge clk) begin
            if (we && mask[c]) mem[addr] <= wdata;
         end
         assign rdata_all[c] = mem[addr];
      end
   endgenerate
endmodule

// File: rtl/burst_ram_port.sv
module burst_ram_port #(
   parameter int NUM_CH      = 4,
   parameter int TONE_DEPTH  = 32,
   parameter int COEF_W      = 14,
   parameter int COEF_BLOCKS = 12,
   parameter int BLK_WORDS   = 8
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       cs_n,
   input  logic       slot,
   input  logic [7:0] rx_byte,
   output logic [7:0] tx_byte
);
   localparam int WORD_W     = 16;
   localparam int TONE_AW    = $clog2(TONE_DEPTH);
   localparam int BLK_SHIFT  = $clog2(BLK_WORDS);
   localparam int COEF_DEPTH = COEF_BLOCKS * BLK_WORDS;
   localparam int COEF_AW    = $clog2(COEF_DEPTH);
   localparam int ADDR_W     = (COEF_AW > TONE_AW) ? COEF_AW : TONE_AW;

   generate
      if (COEF_W > WORD_W || COEF_W < 9) begin : g_bad_coef
         $error("COEF_W must lie between 9 and 16");
      end
      if ((1 << BLK_SHIFT) != BLK_WORDS) begin : g_bad_blk
         $error("BLK_WORDS must be a power of two");
      end
   endgenerate

   logic [ADDR_W-1:0]             addr;
   logic [WORD_W-1:0]             wdata, tone_rdata, word;
   logic                          tone_we, coef_we, rd_active, rd_tone, rd_lo;
   logic [NUM_CH-1:0]             mask;
   logic [NUM_CH-1:0][COEF_W-1:0] coef_all;
   logic [COEF_W-1:0]             coef_sel;

   brp_burst_ctrl #(
      .NUM_CH(NUM_CH), .ADDR_W(ADDR_W), .TONE_AW(TONE_AW),
      .BLK_SHIFT(BLK_SHIFT), .COEF_BLOCKS(COEF_BLOCKS), .WORD_W(WORD_W)
   ) ctrl_i (
      .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .slot(slot), .rx_byte(rx_byte),
      .addr_o(addr), .wdata_o(wdata), .tone_we_o(tone_we), .coef_we_o(coef_we),
      .rd_active_o(rd_active), .rd_tone_o(rd_tone), .rd_lo_o(rd_lo), .mask_o(mask)
   );

   brp_tone_ram #(.DEPTH(TONE_DEPTH), .W(WORD_W)) tone_i (
      .clk(clk), .we(tone_we), .addr(addr[TONE_AW-1:0]),
      .wdata(wdata), .rdata(tone_rdata)
   );

   brp_coef_bank #(.NUM_CH(NUM_CH), .DEPTH(COEF_DEPTH), .W(COEF_W)) coef_i (
      .clk(clk), .we(coef_we), .mask(mask), .addr(addr[COEF_AW-1:0]),
      .wdata(wdata[COEF_W-1:0]), .rdata_all(coef_all)
   );

   always_comb begin
      coef_sel = '0;
      for (int c = NUM_CH - 1; c >= 0; c--) begin
         if (mask[c]) coef_sel = coef_all[c];
      end
   end

   assign word    = rd_tone ? tone_rdata : WORD_W'(coef_sel);
   assign tx_byte = !rd_active ? 8'h00 : (rd_lo ? word[7:0] : word[15:8]);

   assert_idle_quiet_R9: assert property (@(posedge clk) disable iff (!rst_n)
      !rd_active |-> (tx_byte == 8'h00));

   assert_coef_pad_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_active && !rd_tone && !rd_lo) |-> (tx_byte[7:6] == 2'b00));
endmodule

// File: tb/burst_ram_port_tb_top.sv
module burst_ram_port_tb_top;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       cs_n = 1'b1;
   logic       slot = 1'b0;
   logic [7:0] rx_byte = 8'h00;
   logic [7:0] tx_byte;

   int checks = 0;
   int errors = 0;
   bit done = 0;

   logic [15:0] tone_m [32];
   logic [13:0] coef_m [4][96];
   logic [3:0]  mask_m = 4'h0;

   always #5 clk = ~clk;

   burst_ram_port dut_i (
      .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .slot(slot),
      .rx_byte(rx_byte), .tx_byte(tx_byte)
   );

   task automatic check(input string tag, input logic [7:0] got, input logic [7:0] exp);
      checks++;
      if (got !== exp) begin
         errors++;
         $display("FAIL %s: got %02h expected %02h", tag, got, exp);
      end
   endtask

   task automatic xfer(input logic [7:0] b, output logic [7:0] got);
      @(negedge clk);
      got = tx_byte;
      rx_byte = b;
      slot = 1'b1;
      @(negedge clk);
      slot = 1'b0;
   endtask

   task automatic cs_on();
      @(negedge clk);
      cs_n = 1'b0;
   endtask

   task automatic cs_off();
      @(negedge clk);
      cs_n = 1'b1;
      @(negedge clk);
   endtask

   function automatic logic [15:0] exp_word(input bit tone, input int addr);
      if (tone) return tone_m[addr];
      for (int c = 0; c < 4; c++) if (mask_m[c]) return {2'b00, coef_m[c][addr]};
      return 16'h0000;
   endfunction

   task automatic set_mask(input logic [3:0] m);
      logic [7:0] g;
      xfer({3'b001, 1'b0, m}, g);
      mask_m = m;
   endtask

   // one burst under an open chip select; max_bytes limits data bytes sent
   task automatic burst(input bit rd, input bit tone, input int field,
                        input int max_bytes, input string tag);
      logic [7:0] g, d;
      logic [15:0] w;
      int sent = 0;
      bit ok = tone || (field < 12);
      int words = tone ? field + 1 : 8;
      int base  = tone ? field : field * 8 + 7;
      xfer({rd, tone, 1'b0, 5'(field)}, g);
      for (int i = 0; i < words; i++) begin
         int a = base - i;
         w = ok ? exp_word(tone, a) : 16'h0000;
         for (int k = 0; k < 2; k++) begin
            if (sent == max_bytes) return;
            if (rd) begin
               xfer(8'h00, g);
               check(tag, g, (k == 0) ? w[15:8] : w[7:0]);
            end else begin
               d = 8'($urandom);
               xfer(d, g);
               if (k == 0) w[15:8] = d;
               else begin
                  w[7:0] = d;
                  if (ok && tone) tone_m[a] = w;
                  if (ok && !tone)
                     for (int c = 0; c < 4; c++) if (mask_m[c]) coef_m[c][a] = w[13:0];
               end
            end
            sent++;
         end
      end
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         errors++;
         $display("FAIL watchdog: got timeout expected completion");
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end

   initial begin
      logic [7:0] g;
      void'($urandom(32'h1234_5EED));
      repeat (3) @(negedge clk);
      check("R9 reset tx", tx_byte, 8'h00);
      rst_n = 1'b1;
      repeat (2) @(negedge clk);

      // R5 R3: fill every coefficient block on all channels
      cs_on(); set_mask(4'hF);
      for (int b = 0; b < 12; b++) burst(0, 0, b, 9999, "R3");
      burst(0, 1, 31, 9999, "R1");
      cs_off();
      check("R9 idle tx", tx_byte, 8'h00);

      cs_on(); burst(1, 1, 31, 9999, "R2 tone read"); cs_off();
      cs_on(); burst(1, 0, 0, 9999, "R4 coef read"); cs_off();
      cs_on(); burst(1, 0, 11, 9999, "R3 coef top block"); cs_off();

      // R8: write then read in one chip select
      cs_on(); burst(0, 1, 1, 9999, "R8"); burst(1, 1, 1, 9999, "R8 back to back"); cs_off();

      // R7: abort after 2.5 words, then a read of the whole range
      cs_on(); burst(0, 1, 5, 5, "R7"); cs_off();
      cs_on(); burst(1, 1, 5, 9999, "R7 abort readback"); cs_off();
      cs_on(); burst(0, 0, 4, 3, "R7"); cs_off();
      cs_on(); burst(1, 0, 4, 9999, "R7 coef abort readback"); cs_off();

      // R5: overlapping masks and priority
      cs_on(); set_mask(4'b0110); burst(0, 0, 5, 9999, "R5"); cs_off();
      cs_on(); set_mask(4'b0100); burst(1, 0, 5, 9999, "R5 ch2 read"); cs_off();
      cs_on(); set_mask(4'b0001); burst(1, 0, 5, 9999, "R5 ch0 untouched"); cs_off();
      cs_on(); set_mask(4'b0000); burst(1, 0, 2, 9999, "R5 empty mask"); cs_off();

      // R6: bad block, trailing mask byte must be swallowed
      cs_on(); set_mask(4'b1000); cs_off();
      cs_on();
      burst(0, 0, 12, 9999, "R6");
      xfer(8'h21, g);
      check("R6 swallowed byte tx", g, 8'h00);
      cs_off();
      cs_on(); burst(1, 0, 7, 9999, "R6 mask kept"); cs_off();
      cs_on(); burst(1, 0, 15, 9999, "R6 bad read zero"); cs_off();

      // random mix
      for (int it = 0; it < 60; it++) begin
         bit tone = 1'($urandom);
         bit rd = 1'($urandom);
         int field = tone ? int'($urandom_range(0, 31)) : int'($urandom_range(0, 13));
         int mx = ($urandom_range(0, 1) == 1) ? 9999 : int'($urandom_range(0, 16));
         cs_on();
         if ($urandom_range(0, 3) == 0) set_mask(4'($urandom));
         burst(rd, tone, field, mx, tone ? "R1 R2 random" : "R3 R5 random");
         cs_off();
      end
      cs_on(); burst(1, 1, 31, 9999, "R2 final tone"); cs_off();
      cs_on(); set_mask(4'hF); cs_off();
      for (int b = 0; b < 12; b++) begin
         cs_on(); burst(1, 0, b, 9999, "R4 final coef"); cs_off();
      end

      done = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end
endmodule